// File: doc/BRIEF.md
# Text-Mode Video Character Pipeline

This block turns a character memory and a font lookup into a 640x480-class video raster. A pair of free-running counters walks an 800-pixel by 525-line frame. Each character cell is 8 pixels wide and CHAR_H lines tall, so the default screen holds 80 by 30 cells. Each cell's code and font row are fetched while the previous cell is still being shifted out. The fetch for each cell is split into two halves. In the first four pixel times the character memory address goes out and the code comes back. In the last four pixel times the font address goes out and the 8-bit glyph row comes back. That row is loaded into a shift register just as the cell becomes visible.

For the left-most cell there is no earlier cell during which its fetch could run. The line therefore starts with a 16-pixel lead-in before the visible area, and that lead-in holds the first fetch. Horizontal sync is placed 16 pixels later than usual, so the line still totals 800 pixels. Both read ports are expected to answer one clock after they are addressed. The colour outputs are three bits per channel. A test input fills the background with a checker pattern made from the pixel position, so the colour ladders can be checked.

Top module: `vga_text_pipe`

## Requirements
- R1: A line is H_LEAD+COLS*8+H_FP+H_SYNC+H_BP pixel clocks long. With the defaults this is 800, and the hsync falling edges are exactly 800 clocks apart.
- R2: hsync_n is low for H_SYNC clocks. It starts at line position H_LEAD+COLS*8+H_FP, which is 672 by default, 16 later than the usual 656. It is high at every other position.
- R3: vsync_n is low for V_SYNC whole lines, starting at line ROWS*CHAR_H+V_FP. The frame is ROWS*CHAR_H+V_FP+V_SYNC+V_BP lines long (525 by default).
- R4: On visible lines, char_addr takes the value row*COLS+col at line position H_LEAD-8+8*col. Here row is the line divided by CHAR_H. This is one cell ahead of the display of that cell. On lines at or below ROWS*CHAR_H, char_addr does not change.
- R5: Three clocks after char_addr is loaded, font_addr takes the value {char_code, line mod CHAR_H}, with the code in the upper CODE_W bits. char_code and font_bits are each taken to be the memory word addressed one clock earlier.
- R6: The pixel at screen column x (line position H_LEAD+x) shows bit 7-(x mod 8) of its cell's glyph row, so the most significant bit is on the left. A set bit gives 7 on all three channels. This includes column 0 of every row.
- R7: red, green and blue are 0 at every position outside the visible COLS*8 by ROWS*CHAR_H area, including the lead-in.
- R8: On visible pixels whose glyph bit is 0, the colour is 0 when test_mode is 0. When test_mode is 1, let p = (x XOR y) mod 256. The colour is then red={0,p[3:2]}, green={0,p[5:4]} and blue={0,p[7:6]}.
- R9: While rst_n is low, hsync_n and vsync_n are 1, and red, green, blue, char_addr and font_addr are 0.
- R10: All outputs are registered. They show the state of counter position P during the clock that follows it, and this delay is the same for all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_mode | input | 1 | Shows the XOR checker background instead of black |
| char_addr | output | AW | Character memory read address |
| char_code | input | CODE_W | Character code, one clock after char_addr |
| font_addr | output | CODE_W+LINE_W | Font lookup address {code, glyph line} |
| font_bits | input | 8 | Glyph row, one clock after font_addr |
| red | output | 3 | Red level |
| green | output | 3 | Green level |
| blue | output | 3 | Blue level |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The hardest case to reach is the left-most column. Its pixel depends on a fetch that completes during the lead-in, before any visible pixel of the line. A directed frame therefore puts a glyph with both edge bits set in the first and last columns of every row, so a prefetch that is one cell late or early shows up at both screen edges. Frames with every cell solid and every cell blank, in both background modes, fill in the boundaries around them. Random code frames with random test_mode follow. The bench locks onto the first vsync fall and then predicts every output on every clock of each frame. A reduced geometry keeps several whole frames within reach, and a second instance with default parameters is used to time the 800-clock line.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
  localparam int CELL_W = 8;
  localparam int PH_W   = 3;
  localparam int CH_W   = 3;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/vtp_timing.sv
module vtp_timing #(
  parameter int H_LEAD = 16,
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 32,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int HCW    = 10,
  parameter int VCW    = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           hs_act,
  output logic           vs_act,
  output logic           vis
);
  localparam int H_TOTAL = H_LEAD + H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam logic [HCW-1:0] H_LAST  = HCW'(H_TOTAL - 1);
  localparam logic [VCW-1:0] V_LAST  = VCW'(V_TOTAL - 1);
  localparam logic [HCW-1:0] HS_BEG  = HCW'(H_LEAD + H_VIS + H_FP);
  localparam logic [HCW-1:0] HS_END  = HCW'(H_LEAD + H_VIS + H_FP + H_SYNC);
  localparam logic [HCW-1:0] HV_BEG  = HCW'(H_LEAD);
  localparam logic [HCW-1:0] HV_END  = HCW'(H_LEAD + H_VIS);
  localparam logic [VCW-1:0] VS_BEG  = VCW'(V_VIS + V_FP);
  localparam logic [VCW-1:0] VS_END  = VCW'(V_VIS + V_FP + V_SYNC);
  localparam logic [VCW-1:0] VV_END  = VCW'(V_VIS);

  logic [HCW-1:0] hcnt_q, hcnt_d;
  logic [VCW-1:0] vcnt_q, vcnt_d;
  logic           h_last, v_last, v_en;

  // next state
  always_comb begin
    h_last = (hcnt_q == H_LAST);
    v_last = (vcnt_q == V_LAST);
    v_en   = h_last;
    hcnt_d = h_last ? '0 : hcnt_q + HCW'(1);
    vcnt_d = v_last ? '0 : vcnt_q + VCW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      if (v_en) vcnt_q <= vcnt_d;
    end
  end

  always_comb begin
    hcnt   = hcnt_q;
    vcnt   = vcnt_q;
    hs_act = (hcnt_q >= HS_BEG) && (hcnt_q < HS_END);
    vs_act = (vcnt_q >= VS_BEG) && (vcnt_q < VS_END);
    vis    = (hcnt_q >= HV_BEG) && (hcnt_q < HV_END) && (vcnt_q < VV_END);
  end

  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q == H_LAST) |=> (hcnt_q == '0));
  p_hrange_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q <= H_LAST));
  p_vwrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q == H_LAST && vcnt_q == V_LAST) |=> (vcnt_q == '0 && hcnt_q == '0));
  p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q != H_LAST) |=> $stable(vcnt_q));
endmodule

// File: rtl/vtp_fetch.sv
module vtp_fetch
  import vtp_pkg::*;
#(
  parameter int COLS   = 80,
  parameter int V_VIS  = 480,
  parameter int H_LEAD = 16,
  parameter int HCW    = 10,
  parameter int VCW    = 10,
  parameter int AW     = 12,
  parameter int CODE_W = 8,
  parameter int LINE_W = 4,
  parameter int FAW    = CODE_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  output logic [AW-1:0]     char_addr,
  input  logic [CODE_W-1:0] char_code,
  output logic [FAW-1:0]    font_addr,
  input  logic [CELL_W-1:0] font_bits,
  output logic              pix_bit
);
  localparam int FETCH0 = H_LEAD - CELL_W;
  localparam int COLW   = HCW - PH_W;
  localparam int ROWW   = VCW - LINE_W;
  localparam logic [HCW-1:0]  F_BEG   = HCW'(FETCH0);
  localparam logic [HCW-1:0]  F_END   = HCW'(FETCH0 + COLS * CELL_W);
  localparam logic [VCW-1:0]  V_END   = VCW'(V_VIS);
  localparam logic [PH_W-1:0] PH_ADDR = PH_W'(0);
  localparam logic [PH_W-1:0] PH_FONT = PH_W'(3);
  localparam logic [PH_W-1:0] PH_LOAD = PH_W'(CELL_W - 1);

  logic [HCW-1:0]    rel;
  logic [PH_W-1:0]   phase;
  logic [COLW-1:0]   col;
  logic [ROWW-1:0]   row;
  logic              in_win, line_on;
  logic              addr_en, font_en;
  logic [AW-1:0]     addr_calc;
  logic [AW-1:0]     char_addr_q;
  logic [FAW-1:0]    font_addr_q, font_addr_d;
  logic [CELL_W-1:0] shift_q, shift_d;

  // next state: first half of a cell reads the code, second half the glyph
  always_comb begin
    rel       = hcnt - F_BEG;
    phase     = rel[PH_W-1:0];
    col       = rel[HCW-1:PH_W];
    row       = vcnt[VCW-1:LINE_W];
    in_win    = (hcnt >= F_BEG) && (hcnt < F_END);
    line_on   = (vcnt < V_END);
    addr_en   = in_win && line_on && (phase == PH_ADDR);
    font_en   = in_win && line_on && (phase == PH_FONT);
    addr_calc = AW'(row) * AW'(COLS) + AW'(col);
    font_addr_d = {char_code, vcnt[LINE_W-1:0]};
    shift_d   = (phase == PH_LOAD) ? font_bits : {shift_q[CELL_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_addr_q <= '0;
      font_addr_q <= '0;
      shift_q     <= '0;
    end else begin
      if (addr_en) char_addr_q <= addr_calc;
      if (font_en) font_addr_q <= font_addr_d;
      shift_q <= shift_d;
    end
  end

  always_comb begin
    char_addr = char_addr_q;
    font_addr = font_addr_q;
    pix_bit   = shift_q[CELL_W-1];
  end

  p_addr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(char_addr_q) |-> (phase == PH_W'(1)));
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !line_on |=> $stable(char_addr_q));
  p_font_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(font_addr_q) |-> (font_addr_q[LINE_W-1:0] == vcnt[LINE_W-1:0]));
endmodule

// File: rtl/vtp_pixel.sv
module vtp_pixel
  import vtp_pkg::*;
#(
  parameter int H_LEAD = 16,
  parameter int HCW    = 10,
  parameter int VCW    = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vis,
  input  logic           hs_act,
  input  logic           vs_act,
  input  logic           test_mode,
  input  logic           pix_bit,
  input  logic [HCW-1:0] hcnt,
  input  logic [VCW-1:0] vcnt,
  output rgb_t           rgb,
  output logic           hsync_n,
  output logic           vsync_n
);
  localparam int NCH   = 3;
  localparam int PAT_W = 2 * NCH;

  logic [PAT_W-1:0] xs, ys, pat;
  logic [CH_W-1:0]  bg [NCH];
  rgb_t             rgb_q, rgb_d;
  logic             hs_q, vs_q;

  // pattern bits above the lowest two: screen x and y, XORed
  always_comb begin
    xs  = PAT_W'((hcnt - HCW'(H_LEAD)) >> 2);
    ys  = PAT_W'(vcnt >> 2);
    pat = xs ^ ys;
  end

  // channel i takes a two-bit slice, MSB forced low (darker half)
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign bg[i] = {1'b0, pat[2*i+1 -: 2]};
  end

  always_comb begin
    rgb_d = '0;
    if (vis) begin
      if (pix_bit) begin
        rgb_d = '1;
      end else if (test_mode) begin
        rgb_d.r = bg[0];
        rgb_d.g = bg[1];
        rgb_d.b = bg[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q <= '0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
    end else begin
      rgb_q <= rgb_d;
      hs_q  <= ~hs_act;
      vs_q  <= ~vs_act;
    end
  end

  always_comb begin
    rgb     = rgb_q;
    hsync_n = hs_q;
    vsync_n = vs_q;
  end

  p_hblank_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_q |-> (rgb_q == '0));
  p_vblank_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_q |-> (rgb_q == '0));
endmodule

// File: rtl/vga_text_pipe.sv
module vga_text_pipe
  import vtp_pkg::*;
#(
  parameter int COLS   = 80,
  parameter int ROWS   = 30,
  parameter int CHAR_H = 16,
  parameter int CODE_W = 8,
  parameter int H_LEAD = 16,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 32,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_VIS   = COLS * CELL_W,
  localparam int V_VIS   = ROWS * CHAR_H,
  localparam int H_TOTAL = H_LEAD + H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HCW     = $clog2(H_TOTAL),
  localparam int VCW     = $clog2(V_TOTAL),
  localparam int AW      = $clog2(COLS * ROWS),
  localparam int LINE_W  = $clog2(CHAR_H),
  localparam int FAW     = CODE_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  output logic [AW-1:0]     char_addr,
  input  logic [CODE_W-1:0] char_code,
  output logic [FAW-1:0]    font_addr,
  input  logic [CELL_W-1:0] font_bits,
  output logic [CH_W-1:0]   red,
  output logic [CH_W-1:0]   green,
  output logic [CH_W-1:0]   blue,
  output logic              hsync_n,
  output logic              vsync_n
);
  logic [1:0]     rst_sync_q;
  logic           rst_s_n;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           hs_act, vs_act, vis, pix_bit;
  rgb_t           rgb;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  vtp_timing #(
    .H_LEAD(H_LEAD), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HCW(HCW), .VCW(VCW)
  ) u_timing (
    .clk(clk), .rst_n(rst_s_n), .hcnt(hcnt), .vcnt(vcnt),
    .hs_act(hs_act), .vs_act(vs_act), .vis(vis)
  );

  vtp_fetch #(
    .COLS(COLS), .V_VIS(V_VIS), .H_LEAD(H_LEAD), .HCW(HCW), .VCW(VCW),
    .AW(AW), .CODE_W(CODE_W), .LINE_W(LINE_W), .FAW(FAW)
  ) u_fetch (
    .clk(clk), .rst_n(rst_s_n), .hcnt(hcnt), .vcnt(vcnt),
    .char_addr(char_addr), .char_code(char_code),
    .font_addr(font_addr), .font_bits(font_bits), .pix_bit(pix_bit)
  );

  vtp_pixel #(
    .H_LEAD(H_LEAD), .HCW(HCW), .VCW(VCW)
  ) u_pixel (
    .clk(clk), .rst_n(rst_s_n), .vis(vis), .hs_act(hs_act), .vs_act(vs_act),
    .test_mode(test_mode), .pix_bit(pix_bit), .hcnt(hcnt), .vcnt(vcnt),
    .rgb(rgb), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  assign red   = rgb.r;
  assign green = rgb.g;
  assign blue  = rgb.b;
endmodule

// File: tb/vga_text_pipe_tb.sv
`timescale 1ns/1ps
module vga_text_pipe_tb;
  // reduced geometry for the frame checks
  localparam int COLS = 10, ROWS = 4, CH = 4;
  localparam int HL = 16, HFP = 8, HSY = 16, HBP = 8;
  localparam int VFP = 2, VSY = 2, VBP = 3;
  localparam int HV = COLS * 8, VV = ROWS * CH;
  localparam int HT = HL + HV + HFP + HSY + HBP;
  localparam int VT = VV + VFP + VSY + VBP;
  localparam int HS0 = HL + HV + HFP, VS0 = VV + VFP;
  localparam int FETCH0 = HL - 8;
  localparam int NF = 8;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst_n, test_mode;
  logic [5:0] char_addr;
  logic [7:0] char_code;
  logic [9:0] font_addr;
  logic [7:0] font_bits;
  logic [2:0] red, green, blue;
  logic hsync_n, vsync_n;

  logic [11:0] d_addr, d_font;
  logic [2:0]  d_r, d_g, d_b;
  logic        d_hs, d_vs;
  logic [7:0]  zero8 = 8'h00;

  logic [7:0] cmem [COLS*ROWS];
  int n_chk, n_fail;
  int unsigned sd;

  always #2 clk = ~clk;

  vga_text_pipe #(
    .COLS(COLS), .ROWS(ROWS), .CHAR_H(CH), .CODE_W(8),
    .H_LEAD(HL), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .char_addr(char_addr), .char_code(char_code),
    .font_addr(font_addr), .font_bits(font_bits),
    .red(red), .green(green), .blue(blue),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  vga_text_pipe u_dflt (
    .clk(clk), .rst_n(rst_n), .test_mode(1'b0),
    .char_addr(d_addr), .char_code(zero8),
    .font_addr(d_font), .font_bits(zero8),
    .red(d_r), .green(d_g), .blue(d_b),
    .hsync_n(d_hs), .vsync_n(d_vs)
  );

  function automatic logic [7:0] font_fn(logic [7:0] code, logic [1:0] line);
    case (code)
      8'd0:    return 8'h00;
      8'd1:    return 8'hFF;
      8'd2:    return 8'h81;
      default: return code ^ (8'h5A >> line);
    endcase
  endfunction

  // synchronous read ports, one clock of latency
  always @(posedge clk) begin
    char_code <= cmem[char_addr];
    font_bits <= font_fn(font_addr[9:2], font_addr[1:0]);
  end

  function automatic logic [8:0] exp_rgb(int h, int v);
    int x, y;
    logic [7:0] fb, p;
    if (h < HL || h >= HL + HV || v >= VV) return 9'd0;
    x  = h - HL;
    y  = v;
    fb = font_fn(cmem[(y / CH) * COLS + x / 8], 2'(y % CH));
    if (fb[7 - (x % 8)]) return 9'h1FF;
    if (!test_mode) return 9'd0;
    p = 8'(x ^ y);
    return {1'b0, p[3:2], 1'b0, p[5:4], 1'b0, p[7:6]};
  endfunction

  function automatic string px_req(int h, int v);
    if (h < HL || h >= HL + HV || v >= VV) return "R7";
    if (exp_rgb(h, v) == 9'h1FF) return "R6";
    return "R8";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // edge columns use code 2 (bits 7 and 0 set) to expose the prefetch
  task automatic load_directed();
    for (int i = 0; i < COLS * ROWS; i++)
      cmem[i] = ((i % COLS) == 0 || (i % COLS) == COLS - 1) ? 8'd2 : 8'(i % 3);
  endtask

  task automatic new_stim(int f);
    case (f)
      1: begin load_directed(); test_mode = 1'b1; end
      2: begin for (int i = 0; i < COLS * ROWS; i++) cmem[i] = 8'd1; test_mode = 1'b1; end
      3: begin for (int i = 0; i < COLS * ROWS; i++) cmem[i] = 8'd0; test_mode = 1'b1; end
      4: begin for (int i = 0; i < COLS * ROWS; i++) cmem[i] = 8'd0; test_mode = 1'b0; end
      default: begin
        for (int i = 0; i < COLS * ROWS; i++) cmem[i] = 8'($urandom_range(0, 255));
        test_mode = 1'($urandom_range(0, 1));
      end
    endcase
  endtask

  task automatic run_frames();
    int bh, bv, frame, rel;
    logic [5:0] prev_addr;
    do @(negedge clk); while (vsync_n !== 1'b0);
    bh = 0; bv = VS0; frame = 0; prev_addr = char_addr;
    while (frame < NF) begin
      chk(px_req(bh, bv), {red, green, blue}, exp_rgb(bh, bv));
      chk("R2 hsync", hsync_n, (bh >= HS0 && bh < HS0 + HSY) ? 0 : 1);
      chk("R3 vsync", vsync_n, (bv >= VS0 && bv < VS0 + VSY) ? 0 : 1);
      rel = bh - FETCH0;
      if (bv >= VV)
        chk("R4 hold", char_addr, prev_addr);
      else if (rel >= 0 && rel < HV && (rel % 8) == 0)
        chk("R4 addr", char_addr, (bv / CH) * COLS + rel / 8);
      if (bv < VV && rel >= 0 && rel < HV && (rel % 8) == 3)
        chk("R5 font", font_addr, {cmem[(bv / CH) * COLS + rel / 8], 2'(bv % CH)});
      prev_addr = char_addr;
      bh++;
      if (bh == HT) begin
        bh = 0; bv++;
        if (bv == VT) bv = 0;
      end
      if (bh == 0 && bv == VV) begin
        frame++;
        new_stim(frame);
      end
      @(negedge clk);
    end
  endtask

  task automatic run_default();
    int lo, hi;
    do @(negedge clk); while (d_hs !== 1'b0);
    for (int k = 0; k < 3; k++) begin
      lo = 0; hi = 0;
      while (d_hs === 1'b0) begin lo++; @(negedge clk); end
      while (d_hs === 1'b1) begin hi++; @(negedge clk); end
      chk("R2 default sync width", lo, 96);
      chk("R1 default line length", lo + hi, 800);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    sd = $urandom(32'd2024);
    rst_n = 1'b0; test_mode = 1'b0;
    load_directed();
    repeat (4) @(negedge clk);
    chk("R9 hsync", hsync_n, 1);
    chk("R9 vsync", vsync_n, 1);
    chk("R9 rgb", {red, green, blue}, 0);
    chk("R9 char_addr", char_addr, 0);
    chk("R9 font_addr", font_addr, 0);
    rst_n = 1'b1;
    fork
      run_frames();
      run_default();
    join
    // every output checked at the same lag: R10
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule